// File: doc/BRIEF.md
# Multi-Channel Shadowed PWM Generator

This block produces several independent pulse-width-modulated outputs from one clock. Software programs it through a simple single-cycle write bus with a combinational read port. A shared control word turns channels on and off. It can be replaced whole, or changed bit by bit through a set alias and a clear alias. Each channel has two registers at a fixed stride. The timing register holds the period count, the two output levels and the prescaler select. The duty register holds the count at which the output enters the active phase and the count at which it leaves it.

Each channel divides the input clock by a selectable power of two from a non-uniform set. Its counter steps once per prescaled tick and runs from zero up to the period count. Writes land in staging registers first. Software writes the duty register and then the timing register. Only the timing write arms a commit, and the armed pair is copied into the running copy when the counter wraps. A waveform in flight is therefore never cut short or stretched. A disabled channel holds its counter at zero and drives its inactive level. Enabling it starts counting at once with whatever is staged.

Top module: `pwm_bank`

## Requirements
- R1: After synchronous reset every output is low, and the control word and all channel registers read back as zero.
- R2: A write at offset 0x00 replaces the whole control word; bit n enables channel n, and reads at 0x00, 0x04 and 0x08 return the control word.
- R3: A write at offset 0x04 sets the control bits that are 1 in the write data, and a write at offset 0x08 clears them; all other bits keep their value.
- R4: Channel n's duty register sits at 0x10 + n*0x20 and its timing register at 0x20 + n*0x20. Both read back their staged contents: duty end in bits 31:16 and duty start in bits 15:0; period count in bits 15:0, active level in 17:16, inactive level in 19:18 and divider select in 22:20, with bits 31:23 reading zero.
- R5: A disabled channel keeps its counter at zero and drives its inactive level, and that level follows the staged timing register.
- R6: An enabled channel's counter takes the values 0 through the period count P, so one period lasts P+1 prescaled ticks. The output is at the active level while start <= count < duty end and at the inactive level otherwise.
- R7: When the duty end is greater than or equal to P, the output stays at the active level for the whole period, apart from any counts below the duty start.
- R8: Divider select codes 0 to 7 give one tick every 1, 2, 4, 8, 16, 64, 256 and 1024 input clocks.
- R9: A level code of 3 drives the pin high; every other code (0, 1, 2) drives it low.
- R10: Writing only the duty register of a running channel leaves its waveform unchanged.
- R11: A timing-register write commits both staged registers. They take effect only when the counter wraps to zero, so no high pulse of an intermediate length appears.
- R12: On enable, the staged settings apply at once. The first enabled clock edge sees count 0, so the output enters the active phase one clock after the enable takes hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for bus, prescalers and counters |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| addr | input | ADDR_W | Byte offset for both write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register at addr (combinational) |
| pwm_out | output | NUM_CH | Registered PWM output, bit n for channel n |

## Verification
The case hardest to reach from the ports is a commit that arrives partway through a running period. Its effect must be deferred to the wrap, and the pins alone do not show where the counter is. The stimulus waits for the falling edge of the output, which places the counter just past the duty end. It then writes a longer duty and commits it. Every high pulse that follows must have either the old or the new length: an early update would show up as a short pulse. The non-uniform divider codes use windows of exactly two periods, so the high-clock totals do not depend on phase.

// File: rtl/pwm_bank_pkg.sv
// Package: shared constants, register field layout and helper functions
// for the multi-channel PWM bank. Assumes a 32-bit data bus.
package pwm_bank_pkg;

    localparam int BUS_W     = 32;
    localparam int CNT_W     = 16;
    localparam int PRESC_W   = 10;   // largest shift selectable by the divider code
    localparam int PER_W     = 23;   // used width of the timing register

    localparam int CTRL_OFS  = 'h00;
    localparam int SET_OFS   = 'h04;
    localparam int CLR_OFS   = 'h08;
    localparam int DUTY_BASE = 'h10;
    localparam int TIME_BASE = 'h20;
    localparam int CH_STRIDE = 'h20;

    // Timing register layout, MSB first: divider 22:20, idle 19:18, active 17:16, period 15:0
    typedef struct packed {
        logic [2:0]       div_sel;
        logic [1:0]       idle_lvl;
        logic [1:0]       act_lvl;
        logic [CNT_W-1:0] period;
    } time_cfg_t;

    // Duty register layout: end of active phase 31:16, start of active phase 15:0
    typedef struct packed {
        logic [CNT_W-1:0] duty_end;
        logic [CNT_W-1:0] duty_start;
    } duty_cfg_t;

    // Map a divider code to its shift amount: 0..4 direct, then 6, 8, 10
    function automatic logic [3:0] div_shift(input logic [2:0] code);
        logic [3:0] c;
        c = {1'b0, code};
        return (code <= 3'd4) ? c : ((c << 1) - 4'd4);
    endfunction

    // Level code to pin value: only code 3 is high
    function automatic logic level_bit(input logic [1:0] code);
        return (code == 2'b11);
    endfunction

endpackage

// File: rtl/pwm_regs.sv
// Register file: control word with set/clear aliases, and per-channel staged
// duty and timing registers at a fixed stride. Emits a one-cycle strobe on
// each timing-register write. Assumes one write per cycle and a
// combinational read on the same address.
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BUS_W-1:0]        wdata,
    output logic [BUS_W-1:0]        rdata,
    output logic [NUM_CH-1:0]       ch_en,
    output duty_cfg_t [NUM_CH-1:0]  duty_stage,
    output time_cfg_t [NUM_CH-1:0]  time_stage,
    output logic [NUM_CH-1:0]       time_wr
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_OFS);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS);

    logic [NUM_CH-1:0] ctrl_q;
    logic [NUM_CH-1:0] mask;

    assign mask  = wdata[NUM_CH-1:0];
    assign ch_en = ctrl_q;

    // Control word: plain write, set alias, clear alias
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL)     ctrl_q <= mask;
            else if (addr == A_SET) ctrl_q <= ctrl_q | mask;
            else if (addr == A_CLR) ctrl_q <= ctrl_q & ~mask;
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(DUTY_BASE + n * CH_STRIDE);
        localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(TIME_BASE + n * CH_STRIDE);

        duty_cfg_t duty_q;
        time_cfg_t time_q;

        assign time_wr[n]    = wr_en && (addr == A_TIME);
        assign duty_stage[n] = duty_q;
        assign time_stage[n] = time_q;

        // Staging registers for this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty_q <= '0;
                time_q <= '0;
            end else if (wr_en) begin
                if (addr == A_DUTY) duty_q <= duty_cfg_t'(wdata);
                if (addr == A_TIME) time_q <= time_cfg_t'(wdata[PER_W-1:0]);
            end
        end
    end

    // Read multiplexer over control and all staged registers
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL || addr == A_SET || addr == A_CLR)
            rdata = BUS_W'(ctrl_q);
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr == ADDR_W'(DUTY_BASE + n * CH_STRIDE))
                rdata = BUS_W'(duty_stage[n]);
            if (addr == ADDR_W'(TIME_BASE + n * CH_STRIDE))
                rdata = BUS_W'(time_stage[n]);
        end
    end

endmodule

// File: rtl/pwm_channel.sv
// One PWM channel: prescaler, period counter, shadow copy of the staged
// settings and registered output. A timing-register strobe arms a commit that
// is applied when the counter wraps. While disabled the running copy tracks
// the staged registers, so enabling applies them at once.
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  duty_cfg_t        duty_stage,
    input  time_cfg_t        time_stage,
    input  logic             time_wr,
    output logic             pwm,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] period_o,
    output logic             wrap_o
);

    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W:0]   span;
    logic [PRESC_W-1:0] presc_lim;
    logic [CNT_W-1:0]   cnt_q;
    duty_cfg_t          duty_run;
    time_cfg_t          time_run;
    logic               armed_q;
    logic               pwm_q;
    logic               tick;
    logic               wrap;
    logic               in_active;

    // Prescaler terminal value from the running divider code
    always_comb begin
        span      = (PRESC_W+1)'(1) << div_shift(time_run.div_sel);
        presc_lim = PRESC_W'(span - (PRESC_W+1)'(1));
    end

    assign tick = (presc_q >= presc_lim);
    assign wrap = tick && (cnt_q >= time_run.period);

    // Active-phase window, widened to the whole period when duty end >= period
    assign in_active = (cnt_q >= duty_run.duty_start) &&
                       ((duty_run.duty_end >= time_run.period) || (cnt_q < duty_run.duty_end));

    // Prescaler, counter, shadow load and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q  <= '0;
            cnt_q    <= '0;
            duty_run <= '0;
            time_run <= '0;
            armed_q  <= 1'b0;
            pwm_q    <= 1'b0;
        end else if (!en) begin
            presc_q  <= '0;
            cnt_q    <= '0;
            duty_run <= duty_stage;
            time_run <= time_stage;
            armed_q  <= 1'b0;
            pwm_q    <= level_bit(time_run.idle_lvl);
        end else begin
            if (tick) begin
                presc_q <= '0;
                cnt_q   <= wrap ? '0 : cnt_q + CNT_W'(1);
            end else begin
                presc_q <= presc_q + PRESC_W'(1);
            end
            if (wrap && armed_q) begin
                duty_run <= duty_stage;
                time_run <= time_stage;
            end
            armed_q <= time_wr | (armed_q & ~wrap);
            pwm_q   <= in_active ? level_bit(time_run.act_lvl) : level_bit(time_run.idle_lvl);
        end
    end

    assign pwm      = pwm_q;
    assign cnt_o    = cnt_q;
    assign period_o = time_run.period;
    assign wrap_o   = wrap;

endmodule

// File: rtl/pwm_bank.sv
// Top of the multi-channel PWM bank: one register file feeding NUM_CH
// identical channels. Assumes ADDR_W is wide enough to reach the last
// channel's timing register.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]             ch_en;
    duty_cfg_t [NUM_CH-1:0]        duty_stage;
    time_cfg_t [NUM_CH-1:0]        time_stage;
    logic [NUM_CH-1:0]             time_wr;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_vec;
    logic [NUM_CH-1:0][CNT_W-1:0]  period_vec;
    logic [NUM_CH-1:0]             wrap_vec;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .ch_en      (ch_en),
        .duty_stage (duty_stage),
        .time_stage (time_stage),
        .time_wr    (time_wr)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        pwm_channel u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (ch_en[n]),
            .duty_stage (duty_stage[n]),
            .time_stage (time_stage[n]),
            .time_wr    (time_wr[n]),
            .pwm        (pwm_out[n]),
            .cnt_o      (cnt_vec[n]),
            .period_o   (period_vec[n]),
            .wrap_o     (wrap_vec[n])
        );
    end

endmodule

// File: rtl/pwm_bank_checker.sv
// Assertion checker for pwm_bank, attached by bind. Watches the control
// aliases, idle counters, counter range and hold of the running settings.
module pwm_bank_checker
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en,
    input logic [ADDR_W-1:0]              addr,
    input logic [NUM_CH-1:0]              wr_mask,
    input logic [NUM_CH-1:0]              ch_en,
    input logic [NUM_CH-1:0][CNT_W-1:0]   cnt_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0]   period_vec,
    input logic [NUM_CH-1:0]              wrap_vec
);

    // R3: set alias sets every masked bit
    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(SET_OFS)) |=> ((ch_en & $past(wr_mask)) == $past(wr_mask)));

    // R3: clear alias clears every masked bit
    a_r3_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(CLR_OFS)) |=> ((ch_en & $past(wr_mask)) == '0));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // R5: idle channel counter sits at zero
        a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[n] |=> (cnt_vec[n] == '0));

        // R6: counter never passes the running period
        a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_vec[n] <= period_vec[n]);

        // R11: running settings change only at a wrap while enabled
        a_r11_hold_until_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[n] && !wrap_vec[n]) |=> $stable(period_vec[n]));
    end

endmodule

bind pwm_bank pwm_bank_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_mask    (wdata[NUM_CH-1:0]),
    .ch_en      (ch_en),
    .cnt_vec    (cnt_vec),
    .period_vec (period_vec),
    .wrap_vec   (wrap_vec)
);

// File: tb/test_pwm_bank.sv
// Bench for pwm_bank: a table of waveform settings on channel 0, each judged by
// high-clock count over exactly two periods, then directed register, idle,
// commit and enable tests.
module test_pwm_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 2;
    localparam int ADDR_W = 8;
    localparam int NV = 12;

    // Table columns: divider code, period, duty end, duty start, active code, idle code
    localparam int V_DIV  [NV] = '{0, 1, 0, 0, 0, 0, 5, 7, 0, 2, 3, 6};
    localparam int V_PER  [NV] = '{9, 4, 9, 5, 5, 7, 3, 2, 9, 3, 3, 3};
    localparam int V_DUTY [NV] = '{3, 2, 3, 7, 5, 0, 1, 1, 5, 1, 2, 2};
    localparam int V_STRT [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0};
    localparam int V_ACT  [NV] = '{3, 3, 2, 3, 3, 3, 3, 3, 3, 0, 1, 3};
    localparam int V_IDLE [NV] = '{2, 2, 3, 2, 2, 2, 2, 2, 2, 3, 2, 2};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NUM_CH-1:0] pwm_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_pwm_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b0; addr = ADDR_W'(a);
        #1 d = rdata;
    endtask

    function automatic int shift_of(input int code);
        return (code <= 4) ? code : 2 * code - 4;
    endfunction

    function automatic logic [31:0] time_word(input int dv, input int idle, input int act, input int per);
        return (32'(dv) << 20) | (32'(idle) << 18) | (32'(act) << 16) | 32'(per);
    endfunction

    // Expected high clocks per period from R6, R7, R8, R9
    function automatic int exp_high(input int dv, input int per, input int duty, input int st,
                                    input int act, input int idle);
        int hi_end, a_len, ones;
        hi_end = (duty >= per) ? per + 1 : duty;
        a_len  = (hi_end > st) ? hi_end - st : 0;
        ones   = ((act == 3) ? a_len : 0) + ((idle == 3) ? (per + 1 - a_len) : 0);
        return ones << shift_of(dv);
    endfunction

    task automatic count_high(input int ch, input int cycles, output int ones);
        ones = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) ones++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int ones;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pwm_out in reset", pwm_out, 0);
        rst_n = 1'b1;
        bus_read('h00, rd); check("R1 control after reset", rd, 0);
        bus_read('h10, rd); check("R1 duty reg after reset", rd, 0);
        bus_read('h20, rd); check("R1 timing reg after reset", rd, 0);
        count_high(0, 10, ones); check("R1 output low after reset", ones, 0);

        // Table walk on channel 0: R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            int per_len, got;
            string tag;
            per_len = (V_PER[v] + 1) << shift_of(V_DIV[v]);
            bus_write('h08, 32'h1);
            bus_write('h10, (32'(V_DUTY[v]) << 16) | 32'(V_STRT[v]));
            bus_write('h20, time_word(V_DIV[v], V_IDLE[v], V_ACT[v], V_PER[v]));
            bus_write('h04, 32'h1);
            repeat (3) @(negedge clk);
            count_high(0, 2 * per_len, got);
            tag = $sformatf("R6 R7 R8 R9 vector %0d", v);
            check(tag, got, 2 * exp_high(V_DIV[v], V_PER[v], V_DUTY[v], V_STRT[v], V_ACT[v], V_IDLE[v]));
        end

        // R2: plain control write replaces the word
        bus_write('h00, 32'h2);
        bus_read('h00, rd); check("R2 plain control write", rd, 2);
        // R3: set and clear aliases
        bus_write('h04, 32'h1);
        bus_read('h04, rd); check("R3 set alias", rd, 3);
        bus_write('h08, 32'h2);
        bus_read('h08, rd); check("R3 clear alias", rd, 1);

        // R4: channel 1 registers at stride addresses
        bus_write('h30, 32'h0004_0000);
        bus_write('h40, time_word(0, 3, 2, 9));
        bus_read('h30, rd); check("R4 channel 1 duty readback", rd, 32'h0004_0000);
        bus_read('h40, rd); check("R4 channel 1 timing readback", rd, 32'h000E_0009);
        bus_write('h40, 32'hFF8E_0009);
        bus_read('h40, rd); check("R4 timing upper bits read zero", rd, 32'h000E_0009);
        bus_read('h10, rd); check("R4 channel 0 duty untouched", rd, (32'(V_DUTY[NV-1]) << 16));

        // R5: disabled channel 1 drives its staged idle level
        count_high(1, 20, ones); check("R5 idle level high", ones, 20);
        bus_write('h40, time_word(0, 2, 3, 9));
        repeat (2) @(negedge clk);
        count_high(1, 20, ones); check("R5 idle level low", ones, 0);

        // R12: enable applies staged settings at once, count starts at zero
        bus_write('h04, 32'h2);
        @(negedge clk); check("R12 first enabled output", pwm_out[1], 1);
        count_high(1, 3, ones); check("R12 first pulse remainder", ones, 3);
        @(negedge clk); check("R12 first pulse ends", pwm_out[1], 0);

        // R10: duty-only write on running channel 0 changes nothing
        bus_write('h08, 32'h1);
        bus_write('h10, 32'h0003_0000);
        bus_write('h20, time_word(0, 2, 3, 9));
        bus_write('h04, 32'h1);
        repeat (3) @(negedge clk);
        bus_write('h10, 32'h0007_0000);
        repeat (3) @(negedge clk);
        count_high(0, 20, ones); check("R10 duty write alone ignored", ones, 6);

        // R11: commit right after a falling edge, deferred to the wrap
        begin
            logic prev;
            int run, bad;
            prev = pwm_out[0];
            forever begin
                @(negedge clk);
                if (prev && !pwm_out[0]) break;
                prev = pwm_out[0];
            end
            bus_write('h20, time_word(0, 2, 3, 9));
            run = 0; bad = 0; prev = 1'b0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (pwm_out[0]) run++;
                else begin
                    if (prev && run != 3 && run != 7) bad++;
                    run = 0;
                end
                prev = pwm_out[0];
            end
            check("R11 no partial pulse after commit", bad, 0);
            count_high(0, 20, ones); check("R11 new duty after wrap", ones, 14);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule